// File: doc/BRIEF.md
# Four-Source Nested-Priority Interrupt Controller

This block gathers four interrupt sources, each tied to a fixed interrupt number, and presents them to a processor as a single interrupt line. The timer sits on number 0, the second serial port on number 3, the first serial port on number 4 and the network adapter on number 5. A rising edge on a source line records a request. The controller raises `intr` whenever a recorded, unmasked request outranks everything currently being serviced. When the processor acknowledges, the controller hands back an interrupt vector.

Priority is static and fully nested: a lower interrupt number wins. An interrupt that is in service holds off its own level and every level below it. That hold lasts until software writes a specific end-of-interrupt command naming that number. A four-location register port gives access to the mask, the end-of-interrupt command, the pending requests and the in-service set. Every bit field on the port uses the interrupt number as its bit position.

Top module: `intc_top`

## Requirements
- R1: After reset the mask register reads 0x39 (all four sources masked), the request register (address 2) and the in-service register (address 3) read 0x00, and `intr` is low.
- R2: A rising edge on `reqIn[s]` sets the request bit at the source's interrupt number. Slots 0..3 map to numbers 0, 3, 4, 5. A line held high latches only once.
- R3: A masked request stays latched in the request register but does not raise `intr`. Clearing its mask bit raises `intr`.
- R4: `intr` is high exactly when some unmasked pending request has a lower number than every in-service interrupt. The order is 0 > 3 > 4 > 5.
- R5: A one-cycle `intAck` moves the highest-priority eligible request from the request register to the in-service register. In the next cycle `vecValid` pulses with `vecOut` = `VEC_BASE` + interrupt number.
- R6: An acknowledge with no eligible request returns `VEC_BASE` + 7 and leaves the request and in-service registers unchanged.
- R7: A write to address 1 with bits 7:3 zero and bits 2:0 naming an interrupt number clears that number's in-service bit.
- R8: A specific end-of-interrupt write is ignored if it names a number that is not in service, or a number that is not one of the four sources, or if its bits 7:3 are not zero.
- R9: Address 0 is the mask register. Bits 0, 3, 4 and 5 are writable and readable, a 1 masks the source, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 4 | Source lines, slot 0..3 = interrupt numbers 0, 3, 4, 5 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 mask, 1 EOI command, 2 requests, 3 in-service |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from `regAddr` |
| intAck | input | 1 | One-cycle interrupt acknowledge |
| intr | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Interrupt vector, valid with `vecValid` |
| vecValid | output | 1 | Vector valid pulse, one cycle after `intAck` |

## Verification
The bench raises several requests at once and acknowledges them, which catches an inverted or misordered priority encoder: that design would return the wrong vector or move the wrong bit into service. It serves a high level and then raises lower and higher requests while that level is still in service. A design without nesting would raise `intr` for the lower level, and one that blocks too much would miss the higher one. It sends end-of-interrupt commands for idle numbers, for numbers outside the four sources and with stray upper bits. A non-specific or sloppy decode would wrongly clear an in-service bit. It also holds a source line high and acknowledges with nothing eligible, which exposes level-sensitive latching and a spurious acknowledge that changes state.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int N_SRC  = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int NUM_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EOI  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_REQ  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_ISV  = 2'd3;

  localparam logic [NUM_W-1:0] SPURIOUS_NUM = 3'd7;

  // fixed interrupt number of each slot; slot order is priority order
  function automatic logic [NUM_W-1:0] slotNum(input int s);
    case (s)
      0:       slotNum = 3'd0;
      1:       slotNum = 3'd3;
      2:       slotNum = 3'd4;
      default: slotNum = 3'd5;
    endcase
  endfunction

  // spread a per-slot vector onto interrupt-number bit positions
  function automatic logic [DATA_W-1:0] toNumBits(input logic [N_SRC-1:0] v);
    toNumBits = '0;
    for (int s = 0; s < N_SRC; s++) toNumBits[slotNum(s)] = v[s];
  endfunction

  typedef struct packed {
    logic             maskWr;
    logic [N_SRC-1:0] maskVal;
    logic             eoiEn;
    logic [N_SRC-1:0] eoiHot;
    logic             grantEn;
    logic [N_SRC-1:0] grantHot;
  } strobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              intAck,
  input  logic [N_SRC-1:0]  eligible,
  output strobe_t           stb,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid
);
  logic [N_SRC-1:0] winHot;
  logic [NUM_W-1:0] winNum;
  logic             anyElig;
  logic             eoiWellFormed;

  assign anyElig       = |eligible;
  assign eoiWellFormed = (regWrData[DATA_W-1:NUM_W] == '0);

  // fixed priority: lowest slot wins
  always_comb begin
    winHot = '0;
    winNum = SPURIOUS_NUM;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (eligible[s]) begin
        winHot = '0;
        winHot[s] = 1'b1;
        winNum = slotNum(s);
      end
    end
  end

  always_comb begin
    stb = '0;
    stb.maskWr = regWrEn && (regAddr == ADDR_MASK);
    stb.eoiEn  = regWrEn && (regAddr == ADDR_EOI) && eoiWellFormed;
    for (int s = 0; s < N_SRC; s++) begin
      stb.maskVal[s] = regWrData[slotNum(s)];
      stb.eoiHot[s]  = (regWrData[NUM_W-1:0] == slotNum(s));
    end
    stb.grantEn  = intAck && anyElig;
    stb.grantHot = intAck ? winHot : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      vecValid <= intAck;
      if (intAck) vecOut <= VEC_BASE + DATA_W'(winNum);
    end
  end

  a_r5_vec_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> vecValid);
  a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.grantHot));
  a_r6_no_grant_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && eligible == '0) |-> !stb.grantEn);
endmodule

// File: rtl/intc_dpath.sv
module intc_dpath
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_SRC-1:0]  reqIn,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic [N_SRC-1:0]  eligible
);
  logic [N_SRC-1:0] reqPrev, reqEdge;
  logic [N_SRC-1:0] pendReg, maskReg, isvReg;
  logic [N_SRC-1:0] blocked;

  assign reqEdge = reqIn & ~reqPrev;

  // a level is blocked by any in-service interrupt at its own or higher priority
  for (genvar s = 0; s < N_SRC; s++) begin : g_block
    assign blocked[s] = |isvReg[s:0];
  end

  assign eligible = pendReg & ~maskReg & ~blocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev <= '0;
      pendReg <= '0;
      maskReg <= '1;
      isvReg  <= '0;
    end else begin
      reqPrev <= reqIn;
      pendReg <= (pendReg & ~stb.grantHot) | reqEdge;
      if (stb.maskWr) maskReg <= stb.maskVal;
      isvReg <= (isvReg & ~(stb.eoiEn ? stb.eoiHot : '0)) | stb.grantHot;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_MASK: regRdData = toNumBits(maskReg);
      ADDR_REQ:  regRdData = toNumBits(pendReg);
      ADDR_ISV:  regRdData = toNumBits(isvReg);
      default:   regRdData = '0;
    endcase
  end

  a_r5_grant_enters_service: assert property (@(posedge clk) disable iff (!rstN)
    stb.grantEn |=> ((isvReg & $past(stb.grantHot)) != '0));
  a_r4_grant_not_blocked: assert property (@(posedge clk) disable iff (!rstN)
    stb.grantEn |-> ((stb.grantHot & isvReg) == '0 && (stb.grantHot & maskReg) == '0));
  a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoiEn && !stb.grantEn) |=> ((isvReg & $past(stb.eoiHot)) == '0));
  a_r8_eoi_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoiEn && !stb.grantEn && (stb.eoiHot & isvReg) == '0) |=> (isvReg == $past(isvReg)));
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter logic [7:0] VEC_BASE = 8'h20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] reqIn,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       intAck,
  output logic       intr,
  output logic [7:0] vecOut,
  output logic       vecValid
);
  strobe_t          stb;
  logic [N_SRC-1:0] eligible;

  intc_ctrl #(.VEC_BASE(VEC_BASE)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .intAck(intAck), .eligible(eligible),
    .stb(stb), .vecOut(vecOut), .vecValid(vecValid)
  );

  intc_dpath i_dpath (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .stb(stb), .regAddr(regAddr),
    .regRdData(regRdData), .eligible(eligible)
  );

  assign intr = |eligible;
endmodule

// File: tb/test_intc_top.sv
module test_intc_top;
  localparam logic [7:0] VB = 8'h20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] reqIn = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       intAck = 1'b0;
  logic       intr;
  logic [7:0] vecOut;
  logic       vecValid;

  int checks = 0;
  int fails = 0;
  logic [7:0] expQ[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  intc_top i_intc_top (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .intAck(intAck), .intr(intr),
    .vecOut(vecOut), .vecValid(vecValid)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rdChk(string tag, logic [1:0] a, logic [7:0] exp);
    regAddr = a;
    #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic pulse(int s);
    reqIn[s] = 1'b1;
    tick();
    reqIn[s] = 1'b0;
    tick();
  endtask

  // driver: expected vector queued, monitor compares
  task automatic ack(logic [7:0] expVec);
    expQ.push_back(expVec);
    intAck = 1'b1;
    tick();
    intAck = 1'b0;
    tick();
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && vecValid) begin
      if (expQ.size() == 0) chk("R5 unexpected vector", vecOut, 8'hxx);
      else chk("R5/R6 vector", vecOut, expQ.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1
    rdChk("R1 mask", 2'd0, 8'h39);
    rdChk("R1 request", 2'd2, 8'h00);
    rdChk("R1 in-service", 2'd3, 8'h00);
    chk("R1 intr", {7'b0, intr}, 8'h00);
    // R2, R3 masked request
    pulse(3);
    rdChk("R2 request IRQ5", 2'd2, 8'h20);
    chk("R3 masked intr low", {7'b0, intr}, 8'h00);
    // R9
    wr(2'd0, 8'h00);
    rdChk("R9 mask cleared", 2'd0, 8'h00);
    chk("R3 unmask raises intr", {7'b0, intr}, 8'h01);
    wr(2'd0, 8'hFF);
    rdChk("R9 mask only four bits", 2'd0, 8'h39);
    chk("R3 remask drops intr", {7'b0, intr}, 8'h00);
    wr(2'd0, 8'h00);
    // R4, R5 priority
    pulse(2);
    pulse(0);
    rdChk("R2 request set", 2'd2, 8'h31);
    ack(VB + 8'd0);
    rdChk("R5 in-service IRQ0", 2'd3, 8'h01);
    rdChk("R5 request cleared", 2'd2, 8'h30);
    chk("R4 lower blocked", {7'b0, intr}, 8'h00);
    // R6
    ack(VB + 8'd7);
    rdChk("R6 in-service unchanged", 2'd3, 8'h01);
    rdChk("R6 request unchanged", 2'd2, 8'h30);
    // R8
    wr(2'd1, 8'h04);
    rdChk("R8 idle EOI ignored", 2'd3, 8'h01);
    wr(2'd1, 8'h07);
    rdChk("R8 foreign EOI ignored", 2'd3, 8'h01);
    wr(2'd1, 8'h08);
    rdChk("R8 stray upper bits ignored", 2'd3, 8'h01);
    // R7
    wr(2'd1, 8'h00);
    rdChk("R7 EOI IRQ0", 2'd3, 8'h00);
    chk("R4 intr after EOI", {7'b0, intr}, 8'h01);
    ack(VB + 8'd4);
    rdChk("R5 in-service IRQ4", 2'd3, 8'h10);
    chk("R4 IRQ5 below IRQ4", {7'b0, intr}, 8'h00);
    pulse(1);
    chk("R4 IRQ3 above IRQ4", {7'b0, intr}, 8'h01);
    ack(VB + 8'd3);
    rdChk("R4 nested in-service", 2'd3, 8'h18);
    chk("R4 nested intr low", {7'b0, intr}, 8'h00);
    wr(2'd1, 8'h03);
    rdChk("R7 EOI IRQ3", 2'd3, 8'h10);
    chk("R4 still blocked by IRQ4", {7'b0, intr}, 8'h00);
    wr(2'd1, 8'h04);
    chk("R4 IRQ5 released", {7'b0, intr}, 8'h01);
    ack(VB + 8'd5);
    wr(2'd1, 8'h05);
    rdChk("R7 all ended", 2'd3, 8'h00);
    rdChk("R5 requests drained", 2'd2, 8'h00);
    // R2 level held latches once
    reqIn[1] = 1'b1;
    repeat (3) tick();
    ack(VB + 8'd3);
    repeat (3) tick();
    rdChk("R2 held level no relatch", 2'd2, 8'h00);
    reqIn[1] = 1'b0;
    wr(2'd1, 8'h03);
    rdChk("R7 final EOI", 2'd3, 8'h00);
    tick();
    chk("R5 all vectors seen", 8'(expQ.size()), 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule